// File: doc/BRIEF.md
# Stepper Motor Step-Rate Controller

This block issues motor step pulses at a rate that ramps up and down. A programmable delay sets the time between two pulses. The block divides the incoming step clock by two to form a system clock, and every control action happens on the high phase of that clock. Each user command (start, stop, freeze-rate) passes through a debounce filter and a synchronizer before the state machine sees it.

A rising edge of the start command begins a run. The first pulse follows a cleared countdown. After that, each pulse reloads the countdown from the current rate value, and the rate value then moves one unit toward the fastest allowed setting. The freeze command holds the rate value where it is. The stop command makes every later adjustment move the rate value back toward the slowest setting. When the slowest setting is reached, the controller returns to idle.

Top module: `stepper_rate_ctrl`

## Requirements
- R1: `sys_clk` is 0 while reset is asserted and toggles on every `clk` edge after reset. Control outputs and `rate_o` change only at a `clk` edge where `sys_clk` was 1.
- R2: Each command is active low on `go_n` and `halt_n` and active high on `hold`. A new level is accepted only after it has differed from the accepted level for `DEB_CYC` consecutive `clk` cycles. It then passes `SYNC_STAGES` registers clocked on the high phase of `sys_clk`, so a shorter pulse has no effect.
- R3: A run starts only on a rising edge of the conditioned start command while the controller is idle. A start command that stays asserted through a stop does not start a new run.
- R4: `step_n` is low only while `sys_clk` is high in the pulse state, once per pulse. `ld_dly` is high during that whole state. At most one of `ld_zero`, `ld_dly`, `dec_dly_n` (low), `inc_dly` and `set_max` is active at a time.
- R5: At the start of a run, `ld_zero` is high for one system period. The first `step_n` low sample comes 5 `clk` cycles after the first sample with `ld_zero` high.
- R6: If `rate_o` shows p while `step_n` is low, the next pulse begins 2·(p+3) `clk` cycles later.
- R7: Without stop or freeze, each pulse is followed by one system period with `dec_dly_n` low, which lowers `rate_o` by one. This stops once `rate_o` equals `MIN_DLY`.
- R8: While the conditioned freeze command is high, `rate_o` does not change and pulses continue.
- R9: With stop asserted, each pulse is followed by `inc_dly` high, which raises `rate_o` by one. The pulse issued at `MAX_DLY` is the last one, and the controller then returns to idle.
- R10: After reset, and whenever the controller is idle, `set_max` is high and `rate_o` equals `MAX_DLY`.
- R11: `rate_o` always lies between `MIN_DLY` and `MAX_DLY`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_n | input | 1 | Start command, active low, raw |
| halt_n | input | 1 | Stop command, active low, raw |
| hold | input | 1 | Freeze-rate command, active high, raw |
| sys_clk | output | 1 | Step clock divided by two |
| step_n | output | 1 | Step pulse, active low, during the high phase of sys_clk |
| ld_zero | output | 1 | Countdown clear at the start of a run |
| ld_dly | output | 1 | Countdown reload from the rate value |
| dec_dly_n | output | 1 | Rate decrement (speed up), active low |
| inc_dly | output | 1 | Rate increment (slow down) |
| set_max | output | 1 | Rate preset to the slowest value while idle |
| rate_o | output | DW | Current rate value |

## Verification
The checker watches every cycle for several properties: the alternation of the system clock, the rule that outputs stay frozen during its low phase, pulse placement in the high phase, that the control strobes never overlap, the rate bounds, and that every change of the rate value follows the matching strobe. Other behaviour depends on history, so only the bench scenarios can show it. That covers rejection of a short command glitch, edge-only starting with a held start command, the pulse spacing as a function of the loaded rate, the ramp down to the fastest setting, the freeze window, and the return to idle after a stop. A behavioural model is compared with every output on every clock.

// File: rtl/stp_pkg.sv
package stp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_WAIT,
      ST_FIRE,
      ST_FAST,
      ST_SLOW
   } stp_state_e;

   localparam int CMD_NUM  = 3;
   localparam int CMD_GO   = 0;
   localparam int CMD_HALT = 1;
   localparam int CMD_HOLD = 2;

   // polarity per command channel: 1 = active low at the pin
   localparam logic [CMD_NUM-1:0] CMD_ACT_LOW = 3'b011;

endpackage

// File: rtl/stp_clkdiv.sv
module stp_clkdiv (
   input  logic clk,
   input  logic rst_n,
   output logic ph
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= 1'b0;
      else        ph <= ~ph;
   end
endmodule

// File: rtl/stp_cmd_cond.sv
module stp_cmd_cond #(
   parameter int   DEB_CYC     = 16,
   parameter int   SYNC_STAGES = 2,
   parameter logic ACT_LOW     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic raw,
   output logic level
);
   localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;

   logic act;
   logic cap;
   logic filt;
   logic [SYNC_STAGES-1:0] chain;

   generate
      if (ACT_LOW) begin : g_inv
         assign act = ~raw;
      end else begin : g_pass
         assign act = raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap <= 1'b0;
      else        cap <= act;
   end

   generate
      if (DEB_CYC == 1) begin : g_nodeb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt <= 1'b0;
            else        filt <= cap;
         end
      end else begin : g_deb
         logic [CW-1:0] dcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt <= 1'b0;
               dcnt <= '0;
            end else if (cap == filt) begin
               dcnt <= '0;
            end else if (dcnt == CW'(DEB_CYC - 1)) begin
               filt <= cap;
               dcnt <= '0;
            end else begin
               dcnt <= dcnt + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    chain <= '0;
      else if (tick) chain <= {chain[SYNC_STAGES-2:0], filt};
   end

   assign level = chain[SYNC_STAGES-1];
endmodule

// File: rtl/stp_fsm.sv
module stp_fsm
   import stp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic go,
   input  logic halt,
   input  logic hold,
   input  logic cnt,
   input  logic at_max,
   input  logic at_min,
   output logic ld_zero,
   output logic step,
   output logic ld_dly,
   output logic dec_dly,
   output logic inc_dly,
   output logic set_max,
   output logic tmr_dec
);
   stp_state_e st, nxt;
   logic       go_prev;

   always_comb begin
      nxt     = st;
      ld_zero = 1'b0;
      step    = 1'b0;
      ld_dly  = 1'b0;
      dec_dly = 1'b0;
      inc_dly = 1'b0;
      set_max = 1'b0;
      tmr_dec = 1'b0;
      case (st)
         ST_IDLE: begin
            set_max = 1'b1;
            if (go && !go_prev) nxt = ST_START;
         end
         ST_START: begin
            ld_zero = 1'b1;
            nxt     = ST_WAIT;
         end
         ST_WAIT: begin
            if (cnt) nxt = ST_FIRE;
            else     tmr_dec = 1'b1;
         end
         ST_FIRE: begin
            step   = 1'b1;
            ld_dly = 1'b1;
            nxt    = halt ? ST_SLOW : ST_FAST;
         end
         ST_FAST: begin
            dec_dly = !at_min && !hold;
            nxt     = ST_WAIT;
         end
         ST_SLOW: begin
            inc_dly = !at_max && !hold;
            nxt     = at_max ? ST_IDLE : ST_WAIT;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         go_prev <= 1'b0;
      end else if (tick) begin
         st      <= nxt;
         go_prev <= go;
      end
   end
endmodule

// File: rtl/stp_delay_path.sv
module stp_delay_path #(
   parameter int DW      = 8,
   parameter int MIN_DLY = 4,
   parameter int MAX_DLY = 200
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          ld_zero,
   input  logic          ld_dly,
   input  logic          tmr_dec,
   input  logic          dec_dly,
   input  logic          inc_dly,
   input  logic          set_max,
   output logic          cnt,
   output logic          at_max,
   output logic          at_min,
   output logic [DW-1:0] rate
);
   localparam logic [DW-1:0] LIM_HI = DW'(MAX_DLY);
   localparam logic [DW-1:0] LIM_LO = DW'(MIN_DLY);

   logic [DW-1:0] tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr  <= '0;
         rate <= LIM_HI;
      end else if (tick) begin
         if (ld_zero)      tmr <= '0;
         else if (ld_dly)  tmr <= rate;
         else if (tmr_dec) tmr <= tmr - 1'b1;

         if (set_max)      rate <= LIM_HI;
         else if (dec_dly) rate <= rate - 1'b1;
         else if (inc_dly) rate <= rate + 1'b1;
      end
   end

   assign cnt    = (tmr == '0);
   assign at_max = (rate == LIM_HI);
   assign at_min = (rate == LIM_LO);
endmodule

// File: rtl/stepper_rate_ctrl.sv
module stepper_rate_ctrl
   import stp_pkg::*;
#(
   parameter int DW          = 8,
   parameter int MIN_DLY     = 4,
   parameter int MAX_DLY     = 200,
   parameter int DEB_CYC     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_n,
   input  logic          halt_n,
   input  logic          hold,
   output logic          sys_clk,
   output logic          step_n,
   output logic          ld_zero,
   output logic          ld_dly,
   output logic          dec_dly_n,
   output logic          inc_dly,
   output logic          set_max,
   output logic [DW-1:0] rate_o
);
   generate
      if (MAX_DLY <= MIN_DLY) begin : g_bad_lim
         $error("MAX_DLY must exceed MIN_DLY");
      end
      if (MAX_DLY >= (1 << DW)) begin : g_bad_dw
         $error("MAX_DLY does not fit in DW bits");
      end
      if (DEB_CYC < 1) begin : g_bad_deb
         $error("DEB_CYC must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                ph;
   logic [CMD_NUM-1:0]  raw_cmd;
   logic [CMD_NUM-1:0]  cmd;
   logic                cnt, at_max, at_min, step, dec_dly, tmr_dec;

   stp_clkdiv u_div (.clk(clk), .rst_n(rst_n), .ph(ph));

   assign raw_cmd[CMD_GO]   = go_n;
   assign raw_cmd[CMD_HALT] = halt_n;
   assign raw_cmd[CMD_HOLD] = hold;

   for (genvar i = 0; i < CMD_NUM; i++) begin : g_cmd
      stp_cmd_cond #(
         .DEB_CYC     (DEB_CYC),
         .SYNC_STAGES (SYNC_STAGES),
         .ACT_LOW     (CMD_ACT_LOW[i])
      ) u_cond (
         .clk   (clk),
         .rst_n (rst_n),
         .tick  (ph),
         .raw   (raw_cmd[i]),
         .level (cmd[i])
      );
   end

   stp_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (ph),
      .go      (cmd[CMD_GO]),
      .halt    (cmd[CMD_HALT]),
      .hold    (cmd[CMD_HOLD]),
      .cnt     (cnt),
      .at_max  (at_max),
      .at_min  (at_min),
      .ld_zero (ld_zero),
      .step    (step),
      .ld_dly  (ld_dly),
      .dec_dly (dec_dly),
      .inc_dly (inc_dly),
      .set_max (set_max),
      .tmr_dec (tmr_dec)
   );

   stp_delay_path #(
      .DW      (DW),
      .MIN_DLY (MIN_DLY),
      .MAX_DLY (MAX_DLY)
   ) u_path (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (ph),
      .ld_zero (ld_zero),
      .ld_dly  (ld_dly),
      .tmr_dec (tmr_dec),
      .dec_dly (dec_dly),
      .inc_dly (inc_dly),
      .set_max (set_max),
      .cnt     (cnt),
      .at_max  (at_max),
      .at_min  (at_min),
      .rate    (rate_o)
   );

   assign sys_clk   = ph;
   assign step_n    = ~(step & ph);
   assign dec_dly_n = ~dec_dly;
endmodule

// File: rtl/stp_checker.sv
module stp_checker #(
   parameter int DW      = 8,
   parameter int MIN_DLY = 4,
   parameter int MAX_DLY = 200
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sys_clk,
   input logic          step_n,
   input logic          ld_zero,
   input logic          ld_dly,
   input logic          dec_dly_n,
   input logic          inc_dly,
   input logic          set_max,
   input logic [DW-1:0] rate_o
);
   assert_sysclk_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_clk |=> sys_clk);
   assert_sysclk_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sys_clk |=> !sys_clk);
   assert_low_phase_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_clk |=> $stable({ld_zero, ld_dly, dec_dly_n, inc_dly, set_max, rate_o}));
   assert_step_high_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !step_n |-> (sys_clk && ld_dly));
   assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ld_zero, ld_dly, !dec_dly_n, inc_dly, set_max}));
   assert_rate_bounds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_o >= DW'(MIN_DLY)) && (rate_o <= DW'(MAX_DLY)));
   assert_dec_above_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_dly_n |-> (rate_o > DW'(MIN_DLY)));
   assert_rate_fall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_o < $past(rate_o)) |-> !$past(dec_dly_n));
   assert_inc_below_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
      inc_dly |-> (rate_o < DW'(MAX_DLY)));
   assert_rate_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_o > $past(rate_o)) |-> $past(inc_dly || set_max));
endmodule

bind stepper_rate_ctrl stp_checker #(
   .DW      (DW),
   .MIN_DLY (MIN_DLY),
   .MAX_DLY (MAX_DLY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sys_clk   (sys_clk),
   .step_n    (step_n),
   .ld_zero   (ld_zero),
   .ld_dly    (ld_dly),
   .dec_dly_n (dec_dly_n),
   .inc_dly   (inc_dly),
   .set_max   (set_max),
   .rate_o    (rate_o)
);

// File: tb/test_stepper_rate_ctrl.sv
module test_stepper_rate_ctrl;
   localparam int DW   = 6;
   localparam int MIND = 2;
   localparam int MAXD = 8;
   localparam int DEB  = 4;
   localparam int SYN  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go_n = 1'b1, halt_n = 1'b1, hold = 1'b0;
   logic sys_clk, step_n, ld_zero, ld_dly, dec_dly_n, inc_dly, set_max;
   logic [DW-1:0] rate_o;

   always #4 clk = ~clk;

   stepper_rate_ctrl #(.DW(DW), .MIN_DLY(MIND), .MAX_DLY(MAXD),
                       .DEB_CYC(DEB), .SYNC_STAGES(SYN)) i_stepper_rate_ctrl (
      .clk(clk), .rst_n(rst_n), .go_n(go_n), .halt_n(halt_n), .hold(hold),
      .sys_clk(sys_clk), .step_n(step_n), .ld_zero(ld_zero), .ld_dly(ld_dly),
      .dec_dly_n(dec_dly_n), .inc_dly(inc_dly), .set_max(set_max), .rate_o(rate_o));

   int total = 0, bad = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   // states: 0 idle, 1 start, 2 wait, 3 fire, 4 fast, 5 slow
   int m_ph, m_gprev, m_st, m_tmr, m_per;
   int m_cap[3], m_filt[3], m_dc[3], m_s1[3], m_s2[3];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_gprev = 0; m_st = 0; m_tmr = 0; m_per = MAXD;
         for (int i = 0; i < 3; i++) begin
            m_cap[i] = 0; m_filt[i] = 0; m_dc[i] = 0; m_s1[i] = 0; m_s2[i] = 0;
         end
      end else begin
         int raw[3];
         int tick, go, halt, hld, nst, per_old;
         tick = m_ph;
         raw[0] = !go_n; raw[1] = !halt_n; raw[2] = hold;
         go = m_s2[0]; halt = m_s2[1]; hld = m_s2[2];
         for (int i = 0; i < 3; i++) begin
            if (tick != 0) begin m_s2[i] = m_s1[i]; m_s1[i] = m_filt[i]; end
            if (m_cap[i] == m_filt[i]) m_dc[i] = 0;
            else if (m_dc[i] == DEB - 1) begin m_filt[i] = m_cap[i]; m_dc[i] = 0; end
            else m_dc[i]++;
            m_cap[i] = raw[i];
         end
         if (tick != 0) begin
            nst = m_st; per_old = m_per;
            case (m_st)
               0: begin m_per = MAXD; if (go != 0 && m_gprev == 0) nst = 1; end
               1: begin m_tmr = 0; nst = 2; end
               2: begin if (m_tmr == 0) nst = 3; else m_tmr--; end
               3: begin m_tmr = m_per; nst = (halt != 0) ? 5 : 4; end
               4: begin if (hld == 0 && m_per != MIND) m_per--; nst = 2; end
               default: begin
                  if (hld == 0 && m_per != MAXD) m_per++;
                  nst = (per_old == MAXD) ? 0 : 2;
               end
            endcase
            m_st = nst; m_gprev = go;
         end
         m_ph = 1 - m_ph;
      end
   end

   // ---------------- per-clock comparison and pulse monitor ----------------
   longint cyc = 0;
   int steps = 0;
   longint last_step = -1, zero_t = -1;
   int last_rate = 0;
   bit prev_step = 0, prev_zero = 0, first_after_zero = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         bit e_step, hld_s;
         cyc++;
         hld_s  = (m_s2[2] != 0);
         e_step = (m_st == 3) && (m_ph != 0);
         chk(sys_clk == (m_ph != 0), "R1 sys_clk", sys_clk, m_ph);
         chk((!step_n) == e_step, "R4 step_n", step_n, !e_step);
         chk(ld_dly == (m_st == 3), "R4 ld_dly", ld_dly, m_st == 3);
         chk(ld_zero == (m_st == 1), "R5 ld_zero", ld_zero, m_st == 1);
         chk(set_max == (m_st == 0), "R10 set_max", set_max, m_st == 0);
         chk((!dec_dly_n) == (m_st == 4 && !hld_s && m_per != MIND), "R7 dec_dly_n",
             dec_dly_n, !(m_st == 4 && !hld_s && m_per != MIND));
         chk(inc_dly == (m_st == 5 && !hld_s && m_per != MAXD), "R9 inc_dly",
             inc_dly, m_st == 5 && !hld_s && m_per != MAXD);
         chk(int'(rate_o) == m_per, "R11 rate_o", rate_o, m_per);

         if (ld_zero && !prev_zero) begin zero_t = cyc; first_after_zero = 1; end
         if (!step_n && !prev_step) begin
            if (first_after_zero) chk(cyc - zero_t == 5, "R5 first pulse delay",
                                      int'(cyc - zero_t), 5);
            else if (last_step >= 0) chk(cyc - last_step == 2 * (last_rate + 3),
                                         "R6 pulse spacing", int'(cyc - last_step),
                                         2 * (last_rate + 3));
            first_after_zero = 0;
            last_step = cyc; last_rate = rate_o; steps++;
         end
         if (set_max) last_step = -1;
         prev_step = !step_n; prev_zero = ld_zero;
      end
   end

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(8 * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      int s0, r0;
      wait_clk(3);
      chk(sys_clk == 1'b0, "R1 reset sys_clk", sys_clk, 0);
      chk(set_max == 1'b1, "R10 reset set_max", set_max, 1);
      chk(int'(rate_o) == MAXD, "R10 reset rate", rate_o, MAXD);
      chk(step_n == 1'b1, "R10 reset step_n", step_n, 1);
      rst_n = 1'b1;
      wait_clk(10);

      // R2: short glitch is rejected
      go_n = 1'b0; wait_clk(2); go_n = 1'b1;
      wait_clk(60);
      chk(steps == 0, "R2 glitch pulses", steps, 0);
      chk(set_max == 1'b1, "R2 glitch idle", set_max, 1);

      // start a run
      go_n = 1'b0; wait_clk(30); go_n = 1'b1;
      for (int i = 0; i < 400 && steps < 2; i++) wait_clk(1);
      chk(steps >= 2, "R3 run started", steps, 2);

      // R8: freeze
      hold = 1'b1;
      wait_clk(30);
      r0 = rate_o; s0 = steps;
      wait_clk(80);
      chk(int'(rate_o) == r0, "R8 rate frozen", rate_o, r0);
      chk(steps > s0, "R8 pulses continue", steps, s0 + 1);
      hold = 1'b0;

      // R7: ramp down to the fastest setting
      wait_clk(400);
      chk(int'(rate_o) == MIND, "R7 reached min", rate_o, MIND);

      // R9 / R3: stop with start held asserted
      go_n = 1'b0; wait_clk(40);
      halt_n = 1'b0;
      for (int i = 0; i < 1000 && !set_max; i++) wait_clk(1);
      chk(set_max == 1'b1, "R9 back to idle", set_max, 1);
      chk(int'(rate_o) == MAXD, "R9 rate at max", rate_o, MAXD);
      halt_n = 1'b1;
      s0 = steps;
      wait_clk(150);
      chk(steps == s0, "R3 held start no restart", steps, s0);

      // R3: fresh edge restarts
      go_n = 1'b1; wait_clk(40);
      go_n = 1'b0; wait_clk(120);
      chk(steps > s0, "R3 edge restarts", steps, s0 + 1);
      go_n = 1'b1;
      wait_clk(20);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule